// File: doc/BRIEF.md
# Reset-Time Boot Copy Controller

This block decides how a processor core leaves reset. While the system reset is asserted it watches a two-bit boot-mode strap and an endianness strap. The values present when reset is released are kept until the next reset. In one of the three memory-boot modes the controller keeps the core in reset and reads a fixed 1 KB image from an external memory window that starts at 0x9000_0000, the window of chip-enable space 1. It reads in 8-, 16- or 32-bit items, assembles them into 32-bit words and writes the words into on-chip RAM from address 0 upward. After the last word is written it releases the core, which then fetches from address 0.

In host-boot mode nothing is copied. The core stays in reset until a host raises a doorbell bit. The 0-to-1 transition of that bit releases the core.

The external read port uses a plain request/ready handshake. The RAM write port is a single-cycle write strobe with a byte address and a 32-bit word.

Top module: `boot_copy_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that sees `rst` high, `core_rst_o` is 1 and `boot_done_o`, `ext_req_o` and `ram_we_o` are 0.
- R2: `boot_mode_i` and `big_end_i` are taken from the last clock edge at which `rst` is high. Changes after release have no effect until the next reset.
- R3: The mode codes are 00 for host boot, 01 for 8-bit memory boot, 10 for 16-bit memory boot and 11 for 32-bit memory boot. `ext_addr_o` starts at 0x9000_0000 and advances by the item size (1, 2 or 4 bytes) after each accepted read, for 1024 bytes in total. A narrow item is taken from the low bits of `ext_data_i`.
- R4: A read is accepted only at a clock edge where `ext_req_o` and `ext_ready_i` are both high. While `ext_ready_i` is low, `ext_req_o` and `ext_addr_o` hold.
- R5: With `big_end_i` = 0, the first item read for a word goes to the least significant end: bits 7:0 for bytes, 15:0 for halfwords.
- R6: With `big_end_i` = 1, the first item read for a word goes to the most significant end: bits 31:24 for bytes, 31:16 for halfwords. In 32-bit mode the word is written unchanged.
- R7: In the cycle after the read that completes a word, `ram_we_o` is high with `ram_addr_o` equal to the byte offset of that word. This offset is word aligned and starts at 0. A copy makes exactly 256 writes.
- R8: `core_rst_o` stays 1 through the whole copy. It drops, and `boot_done_o` rises with it, one cycle after the final RAM write.
- R9: In host-boot mode no read or write happens. The core is released in the cycle after a clock edge that sees `host_bell_i` go from 0 to 1. A level held high through reset does not count as a transition.
- R10: The doorbell has no effect in memory-boot mode. Once released, the core stays released, with no further reads, until the next reset.
- R11: A reset in the middle of a copy abandons it. The next boot starts again from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| boot_mode_i | input | 2 | Boot-mode strap, captured at reset release |
| big_end_i | input | 1 | Byte-order strap for packing, 1 = big endian |
| host_bell_i | input | 1 | Host doorbell bit; a rising transition releases the core in host mode |
| ext_req_o | output | 1 | External read request |
| ext_addr_o | output | 32 | External read byte address |
| ext_ready_i | input | 1 | External read data valid this cycle |
| ext_data_i | input | 32 | External read data; narrow items in the low bits |
| ram_we_o | output | 1 | On-chip RAM write strobe |
| ram_addr_o | output | 10 | On-chip RAM byte address of the written word |
| ram_wdata_o | output | 32 | Packed word written to RAM |
| core_rst_o | output | 1 | Reset held on the core, 1 = held |
| boot_done_o | output | 1 | Boot sequence complete, core running |

## Verification
If the source offset is wrong, `ext_addr_o` shows a bad address one cycle after the read that caused it. The word written from that read is also wrong in the cycle after its word completes. If the lane position or the byte order is wrong, the fault appears in `ram_wdata_o` in the write cycle of the first affected word. A sequencer that releases too early shows `core_rst_o` low while requests or writes are still pending. One that releases too late shows the gap between the final write and the release as longer than one cycle. A doorbell edge detector that is wrong either releases a memory boot early or misses the host release by one or more cycles. Both are visible at `core_rst_o` at once.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

    typedef enum logic [1:0] {
        BM_HOST = 2'b00,
        BM_BYTE = 2'b01,
        BM_HALF = 2'b10,
        BM_WORD = 2'b11
    } boot_mode_e;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_COPY,
        SQ_FLUSH,
        SQ_HOST,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        boot_mode_e mode;
        logic       big_end;
    } boot_cfg_t;

    localparam int WORD_W = 32;

    // bytes moved per accepted external read
    function automatic logic [2:0] step_bytes(input boot_mode_e m);
        case (m)
            BM_BYTE: return 3'd1;
            BM_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // true when the read at this sub-word offset fills the last lane
    function automatic logic lane_last(input logic [1:0] off_lo, input boot_mode_e m);
        logic [2:0] sum;
        sum = {1'b0, off_lo} + step_bytes(m);
        return sum[2];
    endfunction

    // merge one narrow item into the partially built word
    function automatic logic [WORD_W-1:0] place_item(
        input logic [WORD_W-1:0] acc,
        input logic [WORD_W-1:0] item,
        input logic [1:0]        lane,
        input boot_mode_e        m,
        input logic              be
    );
        logic [WORD_W-1:0] r;
        int                p;
        r = acc;
        case (m)
            BM_BYTE: begin
                p = be ? (3 - int'(lane)) : int'(lane);
                r[p*8 +: 8] = item[7:0];
            end
            BM_HALF: begin
                p = be ? (1 - int'(lane[1])) : int'(lane[1]);
                r[p*16 +: 16] = item[15:0];
            end
            default: r = item;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/boot_cfg_latch.sv
module boot_cfg_latch
    import boot_copy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       big_end_i,
    output boot_cfg_t  cfg_o
);
    boot_cfg_t cfg_q;

    // follows the straps while reset is held, frozen once it is released
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode    <= boot_mode_e'(mode_i);
            cfg_q.big_end <= big_end_i;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_copy_pkg::*;
#(
    parameter int          IMAGE_BYTES = 1024,
    parameter logic [31:0] BASE_ADDR   = 32'h9000_0000,
    localparam int         OFF_W       = $clog2(IMAGE_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  boot_cfg_t        cfg_i,
    input  logic             bell_i,
    input  logic             ready_i,
    output logic             req_o,
    output logic [31:0]      addr_o,
    output logic             take_o,
    output logic [OFF_W-1:0] off_o,
    output logic             core_rst_o,
    output logic             done_o
);
    seq_state_e       state_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_nx;
    logic             bell_q;
    logic             bell_rise;

    assign req_o     = (state_q == SQ_COPY);
    assign take_o    = req_o & ready_i;
    assign off_nx    = off_q + OFF_W'(step_bytes(cfg_i.mode));
    assign bell_rise = bell_i & ~bell_q;
    assign addr_o    = BASE_ADDR + 32'(off_q);
    assign off_o     = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_BOOT;
            off_q   <= '0;
            bell_q  <= 1'b1;
        end else begin
            bell_q <= bell_i;
            case (state_q)
                SQ_BOOT: begin
                    off_q   <= '0;
                    state_q <= (cfg_i.mode == BM_HOST) ? SQ_HOST : SQ_COPY;
                end
                SQ_COPY: begin
                    if (take_o) begin
                        off_q <= off_nx;
                        if (off_nx == OFF_W'(IMAGE_BYTES)) state_q <= SQ_FLUSH;
                    end
                end
                SQ_FLUSH: state_q <= SQ_RUN;
                SQ_HOST:  if (bell_rise) state_q <= SQ_RUN;
                default:  state_q <= SQ_RUN;
            endcase
        end
    end

    assign core_rst_o = (state_q != SQ_RUN);
    assign done_o     = (state_q == SQ_RUN);
endmodule

// File: rtl/boot_word_packer.sv
module boot_word_packer
    import boot_copy_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  boot_cfg_t         cfg_i,
    input  logic              take_i,
    input  logic [WORD_W-1:0] item_i,
    input  logic [RAM_AW-1:0] off_i,
    output logic              wr_o,
    output logic [RAM_AW-1:0] waddr_o,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nx;
    logic              last;
    logic              wr_q;
    logic [RAM_AW-1:0] waddr_q;
    logic [WORD_W-1:0] word_q;

    assign acc_nx = place_item(acc_q, item_i, off_i[1:0], cfg_i.mode, cfg_i.big_end);
    assign last   = lane_last(off_i[1:0], cfg_i.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            wr_q    <= 1'b0;
            waddr_q <= '0;
            word_q  <= '0;
        end else begin
            wr_q <= 1'b0;
            if (take_i) begin
                if (last) begin
                    word_q  <= acc_nx;
                    waddr_q <= {off_i[RAM_AW-1:2], 2'b00};
                    wr_q    <= 1'b1;
                    acc_q   <= '0;
                end else begin
                    acc_q <= acc_nx;
                end
            end
        end
    end

    assign wr_o    = wr_q;
    assign waddr_o = waddr_q;
    assign word_o  = word_q;
endmodule

// File: rtl/boot_copy_ctrl.sv
module boot_copy_ctrl
    import boot_copy_pkg::*;
#(
    parameter int          IMAGE_BYTES = 1024,
    parameter logic [31:0] BASE_ADDR   = 32'h9000_0000,
    localparam int         RAM_AW      = $clog2(IMAGE_BYTES),
    localparam int         OFF_W       = RAM_AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        boot_mode_i,
    input  logic              big_end_i,
    input  logic              host_bell_i,
    output logic              ext_req_o,
    output logic [31:0]       ext_addr_o,
    input  logic              ext_ready_i,
    input  logic [31:0]       ext_data_i,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [31:0]       ram_wdata_o,
    output logic              core_rst_o,
    output logic              boot_done_o
);
    boot_cfg_t        cfg;
    logic             take;
    logic [OFF_W-1:0] off;

    boot_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (boot_mode_i),
        .big_end_i (big_end_i),
        .cfg_o     (cfg)
    );

    boot_sequencer #(
        .IMAGE_BYTES (IMAGE_BYTES),
        .BASE_ADDR   (BASE_ADDR)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg),
        .bell_i     (host_bell_i),
        .ready_i    (ext_ready_i),
        .req_o      (ext_req_o),
        .addr_o     (ext_addr_o),
        .take_o     (take),
        .off_o      (off),
        .core_rst_o (core_rst_o),
        .done_o     (boot_done_o)
    );

    boot_word_packer #(
        .RAM_AW (RAM_AW)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg),
        .take_i  (take),
        .item_i  (ext_data_i),
        .off_i   (off[RAM_AW-1:0]),
        .wr_o    (ram_we_o),
        .waddr_o (ram_addr_o),
        .word_o  (ram_wdata_o)
    );
endmodule

// File: rtl/boot_copy_chk.sv
module boot_copy_chk (
    input logic        clk,
    input logic        rst,
    input logic        ext_req_o,
    input logic        ext_ready_i,
    input logic [31:0] ext_addr_o,
    input logic        ram_we_o,
    input logic [1:0]  ram_addr_lo,
    input logic        core_rst_o,
    input logic        boot_done_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (core_rst_o && !boot_done_o && !ext_req_o && !ram_we_o)); // R1

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_req_o && !ext_ready_i) |=> (ext_req_o && $stable(ext_addr_o))); // R4

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |-> (ram_addr_lo == 2'b00)); // R7

    AST_COPY_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (ext_req_o || ram_we_o) |-> core_rst_o); // R8

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> (!ext_req_o && !ram_we_o)); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_done_o |=> (boot_done_o && !core_rst_o && !ext_req_o)); // R10
endmodule

bind boot_copy_ctrl boot_copy_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_req_o   (ext_req_o),
    .ext_ready_i (ext_ready_i),
    .ext_addr_o  (ext_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_lo (ram_addr_o[1:0]),
    .core_rst_o  (core_rst_o),
    .boot_done_o (boot_done_o)
);

// File: tb/sim_boot_copy_ctrl.sv
module sim_boot_copy_ctrl;
    localparam logic [31:0] BASE = 32'h9000_0000;
    localparam int NWORDS = 256;
    // {mode[1:0], big_end, stall[2:0]}
    localparam logic [5:0] VEC [6] = '{
        {2'b01, 1'b0, 3'd0}, {2'b01, 1'b1, 3'd1}, {2'b10, 1'b0, 3'd2},
        {2'b10, 1'b1, 3'd0}, {2'b11, 1'b0, 3'd1}, {2'b11, 1'b1, 3'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_mode = 2'b01;
    logic        big_end = 1'b0;
    logic        bell = 1'b0;
    logic        ext_ready = 1'b0;
    logic [31:0] ext_data;
    logic        ext_req, ram_we, core_rst, boot_done;
    logic [31:0] ext_addr, ram_wdata;
    logic [9:0]  ram_addr;
    logic [1:0]  cur_mode = 2'b01;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    boot_copy_ctrl u0 (
        .clk (clk), .rst (rst), .boot_mode_i (boot_mode), .big_end_i (big_end),
        .host_bell_i (bell), .ext_req_o (ext_req), .ext_addr_o (ext_addr),
        .ext_ready_i (ext_ready), .ext_data_i (ext_data), .ram_we_o (ram_we),
        .ram_addr_o (ram_addr), .ram_wdata_o (ram_wdata), .core_rst_o (core_rst),
        .boot_done_o (boot_done)
    );

    function automatic logic [7:0] img(input int o);
        return 8'((o * 37 + 11) ^ (o >> 3));
    endfunction

    function automatic logic [31:0] le_word(input int a);
        return {img(a+3), img(a+2), img(a+1), img(a)};
    endfunction

    function automatic logic [31:0] exp_word(input int a, input logic [1:0] m, input logic be);
        if (!be || m == 2'b11) return le_word(a);
        if (m == 2'b01) return {img(a), img(a+1), img(a+2), img(a+3)};
        return {img(a+1), img(a), img(a+3), img(a+2)};
    endfunction

    // external memory model: narrow items in low bits, junk above
    always_comb begin
        int o;
        o = int'(ext_addr - BASE);
        case (cur_mode)
            2'b01:   ext_data = {24'hA5C3E1, img(o)};
            2'b10:   ext_data = {16'h5A3C, img(o+1), img(o)};
            default: ext_data = le_word(o);
        endcase
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [1:0] m, input logic be);
        @(negedge clk);
        rst = 1'b1; boot_mode = m; big_end = be; cur_mode = m; ext_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(core_rst && !boot_done && !ext_req && !ram_we, "R1 reset outputs",
            {28'd0, core_rst, boot_done, ext_req, ram_we}, 32'h8);
        rst = 1'b0;
    endtask

    // run one memory boot; abort_at >= 0 stops early leaving the copy in flight
    task automatic run_boot(input logic [1:0] m, input logic be, input int stall,
                            input int abort_at, output int nwr);
        int exp_off = 0, addr_err = 0, hold_err = 0, stall_err = 0, last_wr = -10;
        int step;
        bit prev_stall = 0, finished = 0;
        logic [31:0] prev_addr = '0;
        step = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 4;
        nwr = 0;
        apply_reset(m, be);
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (c == abort_at) begin
                chk(core_rst && !boot_done, "R11 core held before abort", {31'd0, core_rst}, 32'd1);
                return;
            end
            if (boot_done) begin
                chk(!core_rst, "R8 done and release together", {31'd0, core_rst}, 32'd0);
                chk(last_wr == c - 1, "R8 release one cycle after final write", 32'(c - last_wr), 32'd1);
                finished = 1;
                break;
            end
            if (!core_rst) hold_err++;
            if (ram_we) begin
                chk(ram_addr == 10'(nwr * 4), "R7 write address", {22'd0, ram_addr}, 32'(nwr * 4));
                chk(ram_wdata == exp_word(nwr * 4, m, be), be ? "R6 packed word" : "R5 packed word",
                    ram_wdata, exp_word(nwr * 4, m, be));
                nwr++;
                last_wr = c;
            end
            if (ext_req && ext_addr != BASE + 32'(exp_off)) addr_err++;
            if (prev_stall && (!ext_req || ext_addr != prev_addr)) stall_err++;
            bell = c[2];  // doorbell toggling must not matter here
            ext_ready = (stall == 0) || ((c % (stall + 1)) == stall);
            if (ext_req && ext_ready) exp_off += step;
            prev_stall = ext_req && !ext_ready;
            prev_addr = ext_addr;
        end
        bell = 1'b0;
        chk(finished, "R8 copy finished", {31'd0, finished}, 32'd1);
        chk(addr_err == 0, "R3 source address sequence", 32'(addr_err), 32'd0);
        chk(exp_off == 1024, "R3 total bytes read", 32'(exp_off), 32'd1024);
        chk(stall_err == 0, "R4 hold while not ready", 32'(stall_err), 32'd0);
        chk(nwr == NWORDS, "R7 write count", 32'(nwr), NWORDS);
        chk(hold_err == 0, "R8 R10 core held during copy", 32'(hold_err), 32'd0);
    endtask

    task automatic check_sticky(input string tag);
        int bad = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            bell = c[1];
            boot_mode = 2'(c);
            if (!boot_done || core_rst || ext_req || ram_we) bad++;
        end
        bell = 1'b0;
        chk(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    initial begin
        int nwr;
        int bad;
        // vector table
        for (int v = 0; v < 6; v++) begin
            run_boot(VEC[v][5:4], VEC[v][3], int'(VEC[v][2:0]), -1, nwr);
            check_sticky("R10 stays released after boot");
        end

        // abort mid-copy, then restart from scratch
        run_boot(2'b01, 1'b0, 1, 300, nwr);
        run_boot(2'b10, 1'b1, 1, -1, nwr);
        chk(nwr == NWORDS, "R11 restart copies full image", 32'(nwr), NWORDS);

        // host boot: doorbell held through reset does not count
        @(negedge clk);
        bell = 1'b1;
        apply_reset(2'b00, 1'b0);
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (c == 5) boot_mode = 2'b01;  // late strap change
            if (ext_req || ram_we || !core_rst || boot_done) bad++;
        end
        chk(bad == 0, "R9 host mode idle, core held", 32'(bad), 32'd0);
        chk(!ext_req, "R2 strap change after release ignored", {31'd0, ext_req}, 32'd0);
        bell = 1'b0;
        repeat (3) @(negedge clk);
        chk(core_rst, "R9 falling doorbell does not release", {31'd0, core_rst}, 32'd1);
        bell = 1'b1;
        @(negedge clk);
        chk(!core_rst && boot_done, "R9 release after doorbell rise",
            {30'd0, core_rst, boot_done}, 32'd1);
        check_sticky("R10 host release sticky");

        // mode strap changes after release of a memory boot
        apply_reset(2'b11, 1'b0);
        boot_mode = 2'b00;
        @(negedge clk);
        @(negedge clk);
        chk(ext_req && ext_addr == BASE, "R2 memory boot kept after strap change", ext_addr, BASE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule